// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block is a watchdog whose 6-bit down-counter must be refreshed by software inside a time window, neither too late nor too early. A prescaler divides the input clock by a power of two, chosen by a select field, and each prescaler tick lowers the counter by one. Software refreshes the counter by writing a fixed key to the refresh register. The refresh is accepted only while the count is at or below a programmable window value. A keyed refresh above the window counts as a fault, and so does letting the count run down to zero. Either fault raises a one-clock reset request toward the chip reset controller.

When the count comes down to the window value, a status flag is set. That flag can drive an interrupt, which warns software that the refresh window has opened. A debug input can freeze the count unless software allows it to keep running. Access goes through a single-cycle register bus: writes take effect at the next clock edge, and read data appears in the same cycle as the request.

Top module: `win_wdog`

## Requirements
- R1: After reset, the counter reads 0x3F. The control register, the interrupt-enable register and both status flags read 0, and rst_req_o and irq_o are low.
- R2: While the block is enabled, writing the key 0x00005AA5 to offset 0x00 with the count at or below the window value reloads the counter to 0x3F at the next edge and raises no reset request.
- R3: The following have no effect on the counter or the flags: a write of any other value to offset 0x00, and any refresh write while the block is disabled. A read of offset 0x00 returns 0.
- R4: A key write while the count is above the window value causes a reset request. rst_req_o is high for the cycle after the write, the reset flag (status bit 1) is set, and the counter reloads to 0x3F.
- R5: When the enabled counter holds 0, rst_req_o is high in the following cycle, the reset flag is set, and the counter reloads to 0x3F.
- R6: With prescale select code N in control bits 11:8, the counter decrements once every 2^N enabled clock cycles. Codes above 11 give a ratio of 2^11.
- R7: When a decrement brings the count equal to the window value, status bit 0 is set. irq_o equals status bit 0 AND the interrupt-enable bit (offset 0x08, bit 0).
- R8: Writing 1 to a status bit at offset 0x0C clears it, and writing 0 leaves it unchanged. A set event in the same cycle wins over the clear.
- R9: With control bit 31 at 0 and debug_i high, the counter and the prescaler hold their values. With bit 31 at 1, counting continues while debug_i is high.
- R10: The control register at offset 0x04 reads back as follows: enable in bit 0, prescale select in bits 11:8, window value in bits 21:16, debug-run in bit 31. The counter reads at offset 0x10, bits 5:0. The status register reads at offset 0x0C, bits 1:0. All other bits read 0.
- R11: rst_req_o lasts one cycle per fault, and the counter already reads 0x3F in the cycle the request is visible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as a read request |
| debug_i | input | 1 | System debug state |
| irq_o | output | 1 | Window-open interrupt |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Register writes, counter reloads and flag changes all appear one clock edge after the bus cycle that causes them. rst_req_o rises one edge after the counter holds 0 or after an early key write. Read data is combinational and is due in the same cycle as the request. The bench drives inputs just after the rising edge and steps its reference model on the same rising edge as the design. It compares rst_req_o, irq_o and any read data at the falling edge, so every result is sampled in the cycle it is due and before the next stimulus.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 32;
  localparam int CNT_W     = 6;
  localparam int PSEL_W    = 4;
  localparam int MAX_SHIFT = 11;

  localparam logic [ADDR_W-1:0] OFF_KEY  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_IE   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 5'h10;

  localparam logic [DATA_W-1:0] REFRESH_KEY = 32'h0000_5AA5;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_PSEL_LO = 8;
  localparam int CTRL_WIN_LO  = 16;
  localparam int CTRL_DBG_BIT = 31;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PSEL_W    = 4,
  parameter int MAX_SHIFT = 11,
  localparam int DIV_W    = (MAX_SHIFT > 0) ? MAX_SHIFT : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;
  int unsigned      shift;

  always_comb begin
    shift  = (int'(psel_i) > MAX_SHIFT) ? MAX_SHIFT : int'(psel_i);
    lim    = DIV_W'((32'd1 << shift) - 32'd1);
    // >= keeps a shrinking ratio from wrapping the divider
    tick_o = run_i & ~clr_i & (div_q >= lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (run_i)  div_q <= tick_o ? '0 : div_q + 1'b1;
  end

  p_tick_spacing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (lim != '0) |=> !tick_o || (psel_i != $past(psel_i)))
    else $error("prescaler ticked on consecutive cycles");

  p_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !clr_i |=> $stable(div_q))
    else $error("prescaler moved while halted");
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             key_wr_i,
  input  logic [CNT_W-1:0] win_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o,
  output logic             reload_o,
  output logic             match_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dec;
  logic             early, expired;

  always_comb begin
    early    = key_wr_i & (cnt_q > win_i);
    expired  = en_i & (cnt_q == '0);
    fire_o   = early | expired;
    reload_o = fire_o | key_wr_i;
    dec      = cnt_q - 1'b1;
    match_o  = tick_i & ~reload_o & (dec == win_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= TOP;
    else if (reload_o)  cnt_q <= TOP;
    else if (tick_i)    cnt_q <= dec;
  end

  assign cnt_o = cnt_q;

  p_refresh_in_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr_i && (cnt_q <= win_i) |=> cnt_q == TOP)
    else $error("accepted refresh did not reload");

  p_expire_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (cnt_q == '0) |=> cnt_q == TOP)
    else $error("expired counter did not reload");

  p_hold_without_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !key_wr_i && !(en_i && cnt_q == '0) |=> $stable(cnt_q))
    else $error("counter moved without a tick");
endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              debug_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic              en_q, dbg_run_q, ie_q, if_q, rf_q, rst_req_q;
  logic [PSEL_W-1:0] psel_q;
  logic [CNT_W-1:0]  win_q, cnt;
  logic              wr, wr_ctrl, wr_ie, wr_stat, key_wr;
  logic              run, tick, fire, reload, match;

  always_comb begin
    wr      = req_i & we_i;
    wr_ctrl = wr & (addr_i == OFF_CTRL);
    wr_ie   = wr & (addr_i == OFF_IE);
    wr_stat = wr & (addr_i == OFF_STAT);
    key_wr  = wr & (addr_i == OFF_KEY) & (wdata_i == REFRESH_KEY) & en_q;
    run     = en_q & ~(debug_i & ~dbg_run_q);
  end

  wdog_prescaler #(.PSEL_W(PSEL_W), .MAX_SHIFT(MAX_SHIFT)) i_prescaler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (reload | ~en_q),
    .run_i  (run),
    .psel_i (psel_q),
    .tick_o (tick)
  );

  wdog_core #(.CNT_W(CNT_W)) i_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_q),
    .tick_i   (tick),
    .key_wr_i (key_wr),
    .win_i    (win_q),
    .cnt_o    (cnt),
    .fire_o   (fire),
    .reload_o (reload),
    .match_o  (match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      dbg_run_q <= 1'b0;
      psel_q    <= '0;
      win_q     <= '0;
      ie_q      <= 1'b0;
      if_q      <= 1'b0;
      rf_q      <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q      <= wdata_i[CTRL_EN_BIT];
        dbg_run_q <= wdata_i[CTRL_DBG_BIT];
        psel_q    <= wdata_i[CTRL_PSEL_LO +: PSEL_W];
        win_q     <= wdata_i[CTRL_WIN_LO +: CNT_W];
      end
      if (wr_ie) ie_q <= wdata_i[0];
      // set beats write-one-clear
      if_q      <= match | (if_q & ~(wr_stat & wdata_i[0]));
      rf_q      <= fire  | (rf_q & ~(wr_stat & wdata_i[1]));
      rst_req_q <= fire;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        OFF_CTRL: begin
          rdata_o[CTRL_EN_BIT]                 = en_q;
          rdata_o[CTRL_PSEL_LO +: PSEL_W]      = psel_q;
          rdata_o[CTRL_WIN_LO +: CNT_W]        = win_q;
          rdata_o[CTRL_DBG_BIT]                = dbg_run_q;
        end
        OFF_IE:   rdata_o[0]       = ie_q;
        OFF_STAT: rdata_o[1:0]     = {rf_q, if_q};
        OFF_CNT:  rdata_o[CNT_W-1:0] = cnt;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o     = if_q & ie_q;
  assign rst_req_o = rst_req_q;

  p_early_refresh_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr && (cnt > win_q) |=> rst_req_o && rf_q)
    else $error("early refresh did not request reset");

  p_rf_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat && wdata_i[1] && !fire |=> !rf_q)
    else $error("reset flag not cleared");

  p_reload_on_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> cnt == TOP)
    else $error("counter not reloaded with reset request");

  p_irq_follows_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match && ie_q && !wr_ie |=> irq_o)
    else $error("interrupt missing after window match");
endmodule

// File: tb/test_win_wdog.sv
`timescale 1ns/1ps
module test_win_wdog;
  import wdog_pkg::*;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0, we_i = 1'b0, debug_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              irq_o, rst_req_o;

  always #2 clk = ~clk;

  win_wdog i_win_wdog (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .debug_i(debug_i), .irq_o(irq_o),
    .rst_req_o(rst_req_o)
  );

  int n_cmp = 0, n_bad = 0;
  string rd_tag = "";

  // reference model state
  int m_cnt, m_pre, m_psel, m_win;
  bit m_en, m_dbg, m_ie, m_if, m_rf, m_rst;

  task automatic model_reset();
    m_cnt = 63; m_pre = 0; m_psel = 0; m_win = 0;
    m_en = 0; m_dbg = 0; m_ie = 0; m_if = 0; m_rf = 0; m_rst = 0;
  endtask

  task automatic model_step();
    bit wr, keyw, fire, set_if, halted;
    int ratio, sh;
    wr     = req_i && we_i;
    keyw   = wr && addr_i == 5'h00 && wdata_i == 32'h5AA5 && m_en;
    halted = debug_i && !m_dbg;
    fire   = m_en && (m_cnt == 0 || (keyw && m_cnt > m_win));
    set_if = 0;
    if (fire || keyw) begin
      m_cnt = 63; m_pre = 0;
    end else if (!m_en) begin
      m_pre = 0;
    end else if (!halted) begin
      sh = (m_psel > 11) ? 11 : m_psel;
      ratio = 1 << sh;
      if (m_pre >= ratio - 1) begin
        m_pre = 0;
        m_cnt = m_cnt - 1;
        if (m_cnt == m_win) set_if = 1;
      end else m_pre++;
    end
    if (wr && addr_i == 5'h0C) begin
      if (wdata_i[0]) m_if = 0;
      if (wdata_i[1]) m_rf = 0;
    end
    if (set_if) m_if = 1;
    if (fire) m_rf = 1;
    m_rst = fire;
    if (wr && addr_i == 5'h04) begin
      m_en = wdata_i[0]; m_psel = int'(wdata_i[11:8]);
      m_win = int'(wdata_i[21:16]); m_dbg = wdata_i[31];
    end
    if (wr && addr_i == 5'h08) m_ie = wdata_i[0];
  endtask

  function automatic logic [31:0] model_rd(logic [4:0] a);
    logic [31:0] v = '0;
    case (a)
      5'h04: begin v[0] = m_en; v[11:8] = 4'(m_psel); v[21:16] = 6'(m_win); v[31] = m_dbg; end
      5'h08: v[0] = m_ie;
      5'h0C: v[1:0] = {m_rf, m_if};
      5'h10: v[5:0] = 6'(m_cnt);
      default: v = '0;
    endcase
    return v;
  endfunction

  initial model_reset();
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) model_reset();
    else model_step();
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    chk("R11/R4/R5 rst_req_o", 32'(rst_req_o), 32'(m_rst));
    chk("R7 irq_o", 32'(irq_o), 32'(m_if & m_ie));
    if (req_i && !we_i) chk(rd_tag, rdata_o, model_rd(addr_i));
  end

  task automatic bus_wr(logic [4:0] a, logic [31:0] d);
    @(posedge clk); #1;
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    req_i = 0; we_i = 0; wdata_i = '0;
  endtask

  task automatic bus_rd(logic [4:0] a, string tag);
    @(posedge clk); #1;
    req_i = 1; we_i = 0; addr_i = a; rd_tag = tag;
    @(posedge clk); #1;
    req_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    idle(3);
    #1;
    chk("R1 rst_req_o in reset", 32'(rst_req_o), 32'h0);
    chk("R1 irq_o in reset", 32'(irq_o), 32'h0);
    rst_ni = 1;
    bus_rd(5'h10, "R1 counter after reset");
    bus_rd(5'h0C, "R1 status after reset");
    bus_rd(5'h04, "R1 control after reset");
    bus_rd(5'h00, "R3 refresh register reads 0");
    bus_wr(5'h00, REFRESH_KEY);
    bus_rd(5'h0C, "R3 disabled refresh ignored");

    bus_wr(5'h08, 32'h1);
    bus_wr(5'h04, 32'h0020_0001);
    bus_rd(5'h04, "R10 control fields");
    bus_rd(5'h08, "R10 interrupt enable");
    idle(5);
    bus_rd(5'h10, "R6 divide by one");
    while (m_cnt > 24) @(negedge clk);
    bus_wr(5'h00, 32'h0000_1234);
    bus_rd(5'h10, "R3 wrong key ignored");
    bus_rd(5'h0C, "R7 window flag set");
    bus_wr(5'h00, REFRESH_KEY);
    bus_rd(5'h10, "R2 refresh reloads");
    bus_wr(5'h0C, 32'h1);
    bus_rd(5'h0C, "R8 interrupt flag cleared");

    bus_wr(5'h00, REFRESH_KEY);
    idle(1);
    bus_rd(5'h0C, "R4 early refresh flag");
    bus_rd(5'h10, "R4 early refresh reload");
    bus_wr(5'h0C, 32'h2);
    bus_rd(5'h0C, "R8 reset flag cleared");

    bus_wr(5'h04, 32'h0010_0201);
    begin
      int guard = 0;
      while (!m_rst && guard < 2000) begin @(negedge clk); guard++; end
    end
    bus_rd(5'h0C, "R5 expiry flag");
    bus_rd(5'h10, "R5 expiry reload");

    bus_wr(5'h0C, 32'h3);
    bus_wr(5'h04, 32'h003E_0F01);
    idle(4100);
    bus_rd(5'h10, "R6 saturated divide");

    bus_wr(5'h04, 32'h0005_0001);
    @(posedge clk); #1; debug_i = 1;
    idle(20);
    bus_rd(5'h10, "R9 halted in debug");
    bus_wr(5'h04, 32'h8005_0001);
    idle(10);
    bus_rd(5'h10, "R9 runs in debug");
    @(posedge clk); #1; debug_i = 0;

    bus_wr(5'h08, 32'h0);
    idle(80);
    bus_rd(5'h0C, "R7 flag with interrupt masked");
    bus_wr(5'h04, 32'h0);
    bus_wr(5'h00, REFRESH_KEY);
    bus_rd(5'h10, "R3 refresh after disable ignored");
    idle(2);
    finish_run();
  end
endmodule